// File: doc/BRIEF.md
# Half-Duplex Interframe Gap Deferral Timer

This block decides the moment at which a half-duplex Ethernet transmitter is allowed to start a frame. It watches the carrier-sense input and counts a one-cycle bit-time strobe. When the medium has been quiet long enough, it presents a single grant to the frame sequencer, which then begins the preamble.

The 96-bit-time gap is enforced in two phases. The first is a 60-bit-time sensing window in which the carrier must stay low; any carrier activity there sends the block back to waiting. The second is a 36-bit-time committed wait, during which carrier activity no longer matters. The gap timer also restarts when the local transmitter's own frame ends. A full-duplex input makes the block ignore carrier sense entirely, so that only the gap after the station's own frame is enforced.

Top module: `ifg_defer_timer`

## Requirements
- R1: While reset is asserted, and in the cycles right after it, `tx_grant` is low.
- R2: While half-duplex carrier sense is held high and no gap has completed, `tx_grant` stays low even with a pending request.
- R3: Gap timing starts at the first clock edge where carrier sense is low, `tx_busy` is low and the block is waiting. Bit-time strobes in cycles before that edge are not counted.
- R4: If carrier sense rises before the 60th strobe of the sensing window has been counted, the count is discarded. A full 96-strobe gap is then required after carrier next drops.
- R5: With a strobe every cycle and a pending request, `tx_grant` rises exactly 97 clock edges after carrier sense is first seen low: one edge to start the gap, then 96 strobes.
- R6: Carrier sense that rises after the 60th strobe has no effect. The grant still arises once the 96th strobe is counted, even while carrier stays high.
- R7: The gap advances only in cycles where `bit_tick` is high. A cycle without the strobe never completes the gap.
- R8: While `tx_busy` is high the grant is withdrawn from the next cycle on. When it falls, a fresh 96-strobe gap is required.
- R9: With `full_duplex` high, carrier sense is ignored in every phase. The grant follows 96 strobes after `tx_busy` falls, and it is not withdrawn by carrier.
- R10: Once the gap is complete, `tx_grant` equals `tx_request` in the same cycle. It is never high without a request.
- R11: After the gap is complete, carrier sense rising in half duplex with no pending request cancels the gap. A new full gap is then required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| carrier_sense | input | 1 | Medium busy indication |
| tx_request | input | 1 | A frame is waiting to be sent |
| tx_busy | input | 1 | Local transmitter is sending its own frame |
| full_duplex | input | 1 | Ignore carrier sense |
| tx_grant | output | 1 | Frame may start now |

## Verification
The grant is decoded from the registered phase and the live request, so a request change shows on `tx_grant` in the same cycle. A change of carrier, busy or strobe shows only after the next clock edge. The first gap strobe is counted on the edge after the one that leaves the waiting phase, which puts the grant 97 edges after carrier drops when a strobe arrives every cycle. The bench drives inputs on the falling edge and samples one time unit later, then advances its reference model on the rising edge. In this way every cycle's comparison matches the number of edges counted above, and the explicit checks at edge 96 (low) and edge 97 (high) pin that boundary.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;

    // Phases of the deferral sequence; order is not decoded elsewhere.
    typedef enum logic [1:0] {
        PH_WAIT   = 2'd0,   // medium busy or own frame in flight
        PH_SENSE  = 2'd1,   // carrier must stay low
        PH_COMMIT = 2'd2,   // carrier no longer examined
        PH_OPEN   = 2'd3    // gap satisfied
    } ifg_phase_e;

    typedef struct packed {
        ifg_phase_e phase;
    } ifg_ctrl_s;

endpackage

// File: rtl/ifg_tick_counter.sv
module ifg_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] last_val,
    output logic             at_last
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d.count = '0;
        end else if (advance) begin
            cnt_d.count = cnt_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_last = (cnt_q.count == last_val);

endmodule

// File: rtl/ifg_phase_ctrl.sv
module ifg_phase_ctrl
    import ifg_defer_pkg::*;
#(
    parameter int SENSE_BITS  = 60,
    parameter int COMMIT_BITS = 36,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             carrier_sense,
    input  logic             tx_request,
    input  logic             tx_busy,
    input  logic             full_duplex,
    input  logic             at_last,
    output logic             cnt_clear,
    output logic             cnt_advance,
    output logic [CNT_W-1:0] cnt_last,
    output logic             tx_grant
);

    localparam logic [CNT_W-1:0] SENSE_LAST  = CNT_W'(SENSE_BITS - 1);
    localparam logic [CNT_W-1:0] COMMIT_LAST = CNT_W'(COMMIT_BITS - 1);

    ifg_ctrl_s ctrl_d, ctrl_q;
    logic      medium_busy;
    logic      window_done;

    // Carrier only matters in half duplex.
    assign medium_busy = carrier_sense && !full_duplex;
    assign window_done = bit_tick && at_last;

    always_comb begin
        ctrl_d      = ctrl_q;
        cnt_clear   = 1'b0;
        cnt_advance = 1'b0;
        cnt_last    = (ctrl_q.phase == PH_COMMIT) ? COMMIT_LAST : SENSE_LAST;

        unique case (ctrl_q.phase)
            PH_WAIT: begin
                cnt_clear = 1'b1;
                if (!tx_busy && !medium_busy) begin
                    ctrl_d.phase = PH_SENSE;
                end
            end
            PH_SENSE: begin
                if (medium_busy) begin
                    ctrl_d.phase = PH_WAIT;
                    cnt_clear    = 1'b1;
                end else begin
                    cnt_advance = bit_tick;
                    if (window_done) begin
                        ctrl_d.phase = PH_COMMIT;
                        cnt_clear    = 1'b1;
                    end
                end
            end
            PH_COMMIT: begin
                cnt_advance = bit_tick;
                if (window_done) begin
                    ctrl_d.phase = PH_OPEN;
                    cnt_clear    = 1'b1;
                end
            end
            PH_OPEN: begin
                cnt_clear = 1'b1;
                if (!tx_request && medium_busy) begin
                    ctrl_d.phase = PH_WAIT;
                end
            end
            default: begin
                ctrl_d.phase = PH_WAIT;
                cnt_clear    = 1'b1;
            end
        endcase

        // Own frame in flight overrides every phase.
        if (tx_busy) begin
            ctrl_d.phase = PH_WAIT;
            cnt_clear    = 1'b1;
            cnt_advance  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.phase <= PH_WAIT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign tx_grant = (ctrl_q.phase == PH_OPEN) && tx_request;

endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer #(
    parameter int SENSE_BITS  = 60,
    parameter int COMMIT_BITS = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic carrier_sense,
    input  logic tx_request,
    input  logic tx_busy,
    input  logic full_duplex,
    output logic tx_grant
);

    localparam int LONGEST = (SENSE_BITS > COMMIT_BITS) ? SENSE_BITS : COMMIT_BITS;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    logic             cnt_clear;
    logic             cnt_advance;
    logic [CNT_W-1:0] cnt_last;
    logic             at_last;

    ifg_phase_ctrl #(
        .SENSE_BITS (SENSE_BITS),
        .COMMIT_BITS(COMMIT_BITS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .carrier_sense(carrier_sense),
        .tx_request   (tx_request),
        .tx_busy      (tx_busy),
        .full_duplex  (full_duplex),
        .at_last      (at_last),
        .cnt_clear    (cnt_clear),
        .cnt_advance  (cnt_advance),
        .cnt_last     (cnt_last),
        .tx_grant     (tx_grant)
    );

    ifg_tick_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_advance),
        .last_val(cnt_last),
        .at_last (at_last)
    );

endmodule

// File: rtl/ifg_defer_timer_checker.sv
module ifg_defer_timer_checker #(
    parameter int SENSE_BITS  = 60,
    parameter int COMMIT_BITS = 36
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic carrier_sense,
    input logic tx_request,
    input logic tx_busy,
    input logic full_duplex,
    input logic tx_grant
);

    localparam int GAP   = SENSE_BITS + COMMIT_BITS;
    localparam int GAP_W = $clog2(GAP + 1);

    // Strobes seen since the last own frame or reset, saturating at the gap.
    logic [GAP_W-1:0] ticks_since_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_since_frame <= '0;
        end else if (tx_busy) begin
            ticks_since_frame <= '0;
        end else if (bit_tick && ticks_since_frame < GAP_W'(GAP)) begin
            ticks_since_frame <= ticks_since_frame + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!tx_grant)
                else $error("grant high during reset");
        end
    end

    assert_grant_needs_request_R10: assert property (
        @(posedge clk) disable iff (!rst_n) tx_grant |-> tx_request);

    assert_grant_after_full_gap_R5: assert property (
        @(posedge clk) disable iff (!rst_n) tx_grant |-> (ticks_since_frame == GAP_W'(GAP)));

    assert_own_frame_withdraws_R8: assert property (
        @(posedge clk) disable iff (!rst_n) tx_busy |=> !tx_grant);

    assert_no_progress_without_tick_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tx_request && !tx_grant && !bit_tick) |=> !tx_grant);

    logic unused_ok;
    assign unused_ok = carrier_sense ^ full_duplex;

endmodule

bind ifg_defer_timer ifg_defer_timer_checker #(
    .SENSE_BITS (SENSE_BITS),
    .COMMIT_BITS(COMMIT_BITS)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .carrier_sense(carrier_sense),
    .tx_request   (tx_request),
    .tx_busy      (tx_busy),
    .full_duplex  (full_duplex),
    .tx_grant     (tx_grant)
);

// File: tb/ifg_defer_timer_bench.sv
`timescale 1ns/1ps
module ifg_defer_timer_bench;

    localparam int SENSE = 60;
    localparam int GAP   = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic carrier_sense = 1'b0;
    logic tx_request = 1'b0;
    logic tx_busy = 1'b0;
    logic full_duplex = 1'b0;
    logic tx_grant;

    int    checks = 0;
    int    errors = 0;
    int    gap = -1;          // -1: waiting for an idle medium
    int    tick_div = 1;
    int    tick_phase = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;     // 8 ns period

    ifg_defer_timer u_ifg_defer_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .carrier_sense(carrier_sense),
        .tx_request   (tx_request),
        .tx_busy      (tx_busy),
        .full_duplex  (full_duplex),
        .tx_grant     (tx_grant)
    );

    task automatic check(logic act, logic exp, string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tx_grant=%0b expected=%0b at %0t", t, act, exp, $time);
        end
    endtask

    function automatic logic model_grant();
        return (gap >= GAP) && tx_request;
    endfunction

    // Behavioural reference: gap = strobes counted since the medium went idle.
    task automatic model_step();
        if (!rst_n)                                     gap = -1;
        else if (tx_busy)                               gap = -1;
        else if (gap < 0) begin
            if (full_duplex || !carrier_sense)          gap = 0;
        end
        else if (gap < SENSE && !full_duplex && carrier_sense) gap = -1;
        else if (gap >= GAP) begin
            if (!tx_request && !full_duplex && carrier_sense) gap = -1;
        end
        else if (bit_tick)                              gap = gap + 1;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = (tick_div <= 1) ? 1'b1 : ((tick_phase % tick_div) == 0);
            tick_phase++;
            #1;
            check(tx_grant, model_grant(), tag);
            @(posedge clk);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic expect_grant(logic exp, string t);
        #1;
        check(tx_grant, exp, t);
    endtask

    task automatic own_frame(int len);
        tx_busy = 1'b1;
        cyc(len);
        tx_busy = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset holds grant low even with a request
        tag = "R1"; tx_request = 1'b1;
        cyc(3);
        expect_grant(1'b0, "R1");
        rst_n = 1'b1;
        // R2: busy carrier defers
        tag = "R2"; carrier_sense = 1'b1;
        cyc(150);
        expect_grant(1'b0, "R2");
        // R3 / R5: exact gap after carrier drop
        tag = "R5"; carrier_sense = 1'b0;
        cyc(96);
        expect_grant(1'b0, "R3");
        cyc(1);
        expect_grant(1'b1, "R5");
        // R10: grant tracks request
        tag = "R10"; tx_request = 1'b0;
        expect_grant(1'b0, "R10");
        cyc(2);
        tx_request = 1'b1;
        expect_grant(1'b1, "R10");
        cyc(2);
        // R8: own frame restarts gap
        tag = "R8"; tx_request = 1'b0;
        own_frame(20);
        tx_request = 1'b1;
        cyc(96);
        expect_grant(1'b0, "R8");
        cyc(1);
        expect_grant(1'b1, "R8");
        // R4: carrier inside sensing window restarts
        tag = "R4";
        own_frame(5);
        cyc(30);
        carrier_sense = 1'b1;
        cyc(3);
        carrier_sense = 1'b0;
        cyc(96);
        expect_grant(1'b0, "R4");
        cyc(1);
        expect_grant(1'b1, "R4");
        // R6: carrier in committed phase ignored
        tag = "R6";
        own_frame(5);
        cyc(75);
        carrier_sense = 1'b1;
        cyc(20);
        expect_grant(1'b0, "R6");
        cyc(2);
        expect_grant(1'b1, "R6");
        carrier_sense = 1'b0;
        cyc(2);
        // R11: carrier while open and idle cancels the gap
        tag = "R11"; tx_request = 1'b0;
        cyc(3);
        carrier_sense = 1'b1;
        cyc(2);
        carrier_sense = 1'b0; tx_request = 1'b1;
        expect_grant(1'b0, "R11");
        cyc(97);
        expect_grant(1'b1, "R11");
        // R7: sparse strobes slow the gap
        tag = "R7"; tick_div = 3; tick_phase = 0;
        own_frame(4);
        cyc(150);
        expect_grant(1'b0, "R7");
        cyc(200);
        expect_grant(1'b1, "R7");
        tick_div = 1;
        // R9: full duplex ignores carrier
        tag = "R9"; full_duplex = 1'b1; carrier_sense = 1'b1;
        own_frame(5);
        cyc(96);
        expect_grant(1'b0, "R9");
        cyc(1);
        expect_grant(1'b1, "R9");
        tx_request = 1'b0;
        cyc(5);
        tx_request = 1'b1;
        expect_grant(1'b1, "R9");
        cyc(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule